// File: doc/BRIEF.md
# Connection Memory Range Filler

This engine fills a range of a switch's connection memory with a fixed pattern, so that software does not have to write each location itself. Software sets a go bit. The engine latches the mode pattern and the clear-low choice, then walks the address range in ascending order, one address per clock. At each address it writes the mode pattern into the mode field of the high connection memory word. It can also write zero into the low connection memory word at the same address.

The range is either the whole memory (full-range mode) or the span from a start register to an end register, both ends included. The go bit stays set while the fill runs. The engine drops it when the last location is written. Software can stop the fill early by writing the bit to zero. The busy output lets the surrounding logic block or arbitrate processor accesses to connection memory while the fill is running.

Top module: `cm_block_fill`

## Requirements
- R1: A fill starts only when software writes 1 to the go bit (`sw_we`=1, `sw_go`=1) while the go bit reads 0. Writes of 1 while the go bit is already 1 have no effect.
- R2: With `cfg_full`=1 at the start write, the engine ignores `cfg_start` and `cfg_end` and writes every address from 0 to 2^ADDR_W-1.
- R3: With `cfg_full`=0, the engine writes addresses `cfg_start` through `cfg_end`, both included, in ascending order, one per cycle. The first write falls in the cycle after the start write is taken.
- R4: Every high-memory write (`hi_we`=1) carries the latched 3-bit mode pattern on `hi_mode`. The memory stores it in bits 2..0 of the high word.
- R5: If clear-low was 1 at the start write, each address in the range also gets a low-memory write (`lo_we`=1) of 15 zero bits on `lo_wdata`. If it was 0, `lo_we` stays 0 and the low words are unchanged.
- R6: After the write to the last address, `busy` and `go_bit` both return to 0.
- R7: Writing 0 to the go bit while `busy`=1 aborts the fill. The address written in that same cycle is the last one written, and `busy` and `go_bit` are 0 in the next cycle.
- R8: The mode pattern, the clear-low choice and the range are latched at the start write. Changes to `cfg_*` during the fill do not affect it.
- R9: If `cfg_full`=0 and `cfg_start` > `cfg_end`, a start write performs no memory writes and `go_bit` stays 0.
- R10: `busy` is 1 in exactly the cycles in which a write is presented. A fill of N locations holds `busy` high for N cycles.
- R11: `rst` or `soft_rst` puts the engine in idle with `go_bit`=0 and no writes. A `soft_rst` during a fill ends it in the same way as an abort.
- R12: A write of 1 to the go bit in the final cycle of a fill does not start a new fill. Completion clears the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (pin) |
| soft_rst | input | 1 | Synchronous software reset |
| sw_we | input | 1 | Software write strobe for the go bit |
| sw_go | input | 1 | Value written to the go bit |
| cfg_full | input | 1 | 1: program the whole memory |
| cfg_mode | input | 3 | Mode pattern for the high word |
| cfg_clr_low | input | 1 | 1: zero the low words in the range |
| cfg_start | input | ADDR_W | First address of the range |
| cfg_end | input | ADDR_W | Last address of the range |
| go_bit | output | 1 | Current go bit value |
| busy | output | 1 | Fill in progress |
| hi_we | output | 1 | High memory write enable |
| hi_addr | output | ADDR_W | High memory write address |
| hi_mode | output | 3 | Data for the high word's mode bits |
| lo_we | output | 1 | Low memory write enable |
| lo_addr | output | ADDR_W | Low memory write address |
| lo_wdata | output | 15 | Data for the low word (all zero) |

## Verification
Two events can arrive in the same cycle: the completion of the final address and a software write to the go bit. That write is either an abort (writing 0) or a redundant 1. The bench drives aborts and soft resets at random offsets, including the last cycle of the range. It also drives a directed write of 1 in the final cycle. Each case is judged by the number of busy cycles, the final go bit, one idle cycle after the fill, and the contents of bench-side models of both memories.

// File: rtl/cmf_pkg.sv
package cmf_pkg;
  parameter int CMF_MODE_W = 3;

  typedef struct packed {
    logic [CMF_MODE_W-1:0] mode;
    logic                  clr_low;
  } cmf_cfg_t;
endpackage

// File: rtl/cmf_range_sel.sv
module cmf_range_sel #(
  parameter int ADDR_W = 8
) (
  input  logic              full,
  input  logic [ADDR_W-1:0] start_a,
  input  logic [ADDR_W-1:0] end_a,
  output logic [ADDR_W-1:0] first,
  output logic [ADDR_W-1:0] last,
  output logic              empty
);
  always_comb begin
    if (full) begin
      first = '0;
      last  = '1;
      empty = 1'b0;
    end else begin
      first = start_a;
      last  = end_a;
      empty = (start_a > end_a);
    end
  end
endmodule

// File: rtl/cmf_go_ctl.sv
module cmf_go_ctl (
  input  logic clk,
  input  logic rst,
  input  logic soft_rst,
  input  logic sw_we,
  input  logic sw_go,
  input  logic empty,
  input  logic fin,
  output logic go_q,
  output logic start
);
  // a start needs a 0 -> 1 change of the go bit
  assign start = sw_we & sw_go & ~go_q;

  always_ff @(posedge clk) begin
    if (rst || soft_rst) go_q <= 1'b0;
    else if (start)      go_q <= ~empty;
    else if (fin)        go_q <= 1'b0;
  end

  // R1
  rise_only_chk: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (go_q && sw_we && sw_go && !fin) |=> go_q);
endmodule

// File: rtl/cmf_walker.sv
module cmf_walker
  import cmf_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              start,
  input  logic              empty,
  input  logic              abort,
  input  logic [ADDR_W-1:0] first,
  input  logic [ADDR_W-1:0] last,
  input  cmf_cfg_t          cfg_in,
  output logic              busy,
  output logic [ADDR_W-1:0] cur,
  output cmf_cfg_t          cfg_q,
  output logic              fin
);
  logic [ADDR_W-1:0] last_q;

  assign fin = busy & (abort | (cur == last_q));

  always_ff @(posedge clk) begin
    if (clr) begin
      busy   <= 1'b0;
      cur    <= '0;
      last_q <= '0;
      cfg_q  <= '0;
    end else if (start && !empty) begin
      busy   <= 1'b1;
      cur    <= first;
      last_q <= last;
      cfg_q  <= cfg_in;
    end else if (fin) begin
      busy <= 1'b0;
    end else if (busy) begin
      cur <= cur + 1'b1;
    end
  end

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (clr)
    (busy && !fin) |=> (busy && cur == $past(cur) + 1'b1));
  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (clr)
    (busy && !fin) |=> $stable(cfg_q));
  // R7
  abort_stop_chk: assert property (@(posedge clk) disable iff (clr)
    (busy && abort) |=> !busy);
endmodule

// File: rtl/cm_block_fill.sv
module cm_block_fill
  import cmf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LOW_W  = 15
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  soft_rst,
  input  logic                  sw_we,
  input  logic                  sw_go,
  input  logic                  cfg_full,
  input  logic [CMF_MODE_W-1:0] cfg_mode,
  input  logic                  cfg_clr_low,
  input  logic [ADDR_W-1:0]     cfg_start,
  input  logic [ADDR_W-1:0]     cfg_end,
  output logic                  go_bit,
  output logic                  busy,
  output logic                  hi_we,
  output logic [ADDR_W-1:0]     hi_addr,
  output logic [CMF_MODE_W-1:0] hi_mode,
  output logic                  lo_we,
  output logic [ADDR_W-1:0]     lo_addr,
  output logic [LOW_W-1:0]      lo_wdata
);
  logic              start, empty, fin, abort, clr;
  logic [ADDR_W-1:0] first, last, cur;
  cmf_cfg_t          cfg_in, cfg_q;

  assign clr    = rst | soft_rst;
  assign abort  = sw_we & ~sw_go;
  assign cfg_in = '{mode: cfg_mode, clr_low: cfg_clr_low};

  cmf_range_sel #(.ADDR_W(ADDR_W)) u_range (
    .full(cfg_full), .start_a(cfg_start), .end_a(cfg_end),
    .first(first), .last(last), .empty(empty)
  );

  cmf_go_ctl u_go (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .sw_we(sw_we), .sw_go(sw_go),
    .empty(empty), .fin(fin), .go_q(go_bit), .start(start)
  );

  cmf_walker #(.ADDR_W(ADDR_W)) u_walk (
    .clk(clk), .clr(clr), .start(start), .empty(empty), .abort(abort),
    .first(first), .last(last), .cfg_in(cfg_in),
    .busy(busy), .cur(cur), .cfg_q(cfg_q), .fin(fin)
  );

  assign hi_we    = busy;
  assign hi_addr  = cur;
  assign hi_mode  = cfg_q.mode;
  assign lo_we    = busy & cfg_q.clr_low;
  assign lo_addr  = cur;
  assign lo_wdata = '0;

  // R6
  go_busy_chk: assert property (@(posedge clk) disable iff (rst)
    go_bit == busy);
  // R5
  lo_with_hi_chk: assert property (@(posedge clk) disable iff (rst)
    lo_we |-> hi_we);
  // R9
  empty_start_chk: assert property (@(posedge clk) disable iff (clr)
    (start && empty) |=> (!busy && !go_bit));
endmodule

// File: tb/cm_block_fill_bench.sv
`timescale 1ns/1ps
module cm_block_fill_bench;
  localparam int AW = 5;
  localparam int N  = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1, soft_rst = 1'b0, sw_we = 1'b0, sw_go = 1'b0;
  logic cfg_full = 1'b0, cfg_clr_low = 1'b0;
  logic [2:0] cfg_mode = '0;
  logic [AW-1:0] cfg_start = '0, cfg_end = '0;
  logic go_bit, busy, hi_we, lo_we;
  logic [AW-1:0] hi_addr, lo_addr;
  logic [2:0] hi_mode;
  logic [14:0] lo_wdata;

  logic [2:0]  hm [N];
  logic [14:0] lm [N];
  logic [2:0]  rh [N];
  logic [14:0] rl [N];
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cm_block_fill #(.ADDR_W(AW), .LOW_W(15)) u_cm_block_fill (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .sw_we(sw_we), .sw_go(sw_go),
    .cfg_full(cfg_full), .cfg_mode(cfg_mode), .cfg_clr_low(cfg_clr_low),
    .cfg_start(cfg_start), .cfg_end(cfg_end), .go_bit(go_bit), .busy(busy),
    .hi_we(hi_we), .hi_addr(hi_addr), .hi_mode(hi_mode),
    .lo_we(lo_we), .lo_addr(lo_addr), .lo_wdata(lo_wdata)
  );

  always @(posedge clk) begin
    if (hi_we) hm[hi_addr] <= hi_mode;
    if (lo_we) lm[lo_addr] <= lo_wdata;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_count(bit full, int s, int e, int abort_k);
    int f, l;
    f = full ? 0 : s;
    l = full ? N - 1 : e;
    if (f > l) return 0;
    if (abort_k >= 0 && abort_k < l - f) return abort_k + 1;
    return l - f + 1;
  endfunction

  // abort_k < 0: no abort; use_srst picks soft reset instead of a 0 write
  task automatic run_fill(bit full, int s, int e, logic [2:0] mode, bit clr,
                          int abort_k, bit use_srst, bit last_one, bit noise,
                          string req);
    int n, k, f, cyc, bad_h, bad_l;
    n = exp_count(full, s, e, abort_k);
    f = full ? 0 : s;
    @(negedge clk);
    cfg_full = full; cfg_start = AW'(s); cfg_end = AW'(e);
    cfg_mode = mode; cfg_clr_low = clr;
    sw_we = 1'b1; sw_go = 1'b1;
    @(posedge clk); @(negedge clk);
    sw_we = 1'b0;
    k = 0; cyc = 0;
    while (busy && k < 100) begin
      cyc++;
      // R8: disturb the configuration while running
      cfg_mode = 3'($urandom); cfg_clr_low = 1'($urandom);
      cfg_start = AW'($urandom); cfg_full = 1'($urandom);
      if (k == abort_k) begin
        if (use_srst) soft_rst = 1'b1;
        else begin sw_we = 1'b1; sw_go = 1'b0; end
      end else if ((last_one && k == n - 1) || (noise && $urandom_range(3) == 0)) begin
        sw_we = 1'b1; sw_go = 1'b1;  // R1 / R12: redundant write of 1
      end
      @(posedge clk); k++; @(negedge clk);
      sw_we = 1'b0; soft_rst = 1'b0;
    end
    check(cyc == n, {req, "/R10 busy cycles"}, cyc, n);
    check(go_bit == 1'b0, {req, "/R6 go bit after fill"}, go_bit, 0);
    @(negedge clk);
    check(busy == 1'b0, "R12/R1 no restart", busy, 0);
    for (int a = 0; a < n; a++) begin
      rh[f + a] = mode;
      if (clr) rl[f + a] = '0;
    end
    bad_h = 0; bad_l = 0;
    for (int a = 0; a < N; a++) begin
      if (hm[a] !== rh[a]) bad_h++;
      if (lm[a] !== rl[a]) bad_l++;
    end
    check(bad_h == 0, {req, "/R4/R8 high memory words wrong"}, bad_h, 0);
    check(bad_l == 0, {req, "/R5 low memory words wrong"}, bad_l, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int a = 0; a < N; a++) begin
      hm[a] = 3'($urandom); rh[a] = hm[a];
      lm[a] = 15'($urandom); rl[a] = lm[a];
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!busy && !go_bit && !hi_we && !lo_we, "R11 reset idle",
          {busy, go_bit, hi_we, lo_we}, 0);
    rst = 1'b0;
    run_fill(1'b0, 3, 9, 3'd5, 1'b1, -1, 1'b0, 1'b0, 1'b0, "R3");
    run_fill(1'b0, 12, 12, 3'd2, 1'b0, -1, 1'b0, 1'b0, 1'b0, "R3");
    run_fill(1'b1, 20, 4, 3'd6, 1'b1, -1, 1'b0, 1'b0, 1'b0, "R2");
    run_fill(1'b0, 17, 8, 3'd7, 1'b1, -1, 1'b0, 1'b0, 1'b0, "R9");
    run_fill(1'b0, 2, 14, 3'd1, 1'b0, 4, 1'b0, 1'b0, 1'b0, "R7");
    run_fill(1'b0, 5, 10, 3'd3, 1'b1, 5, 1'b0, 1'b0, 1'b0, "R7");
    run_fill(1'b0, 0, 30, 3'd4, 1'b1, 7, 1'b1, 1'b0, 1'b0, "R11");
    run_fill(1'b0, 6, 11, 3'd0, 1'b1, -1, 1'b0, 1'b1, 1'b0, "R12");
    run_fill(1'b0, 1, 25, 3'd5, 1'b0, -1, 1'b0, 1'b0, 1'b1, "R1");
    for (int i = 0; i < 40; i++) begin
      int s, e, ak;
      s = $urandom_range(N - 1); e = $urandom_range(N - 1);
      ak = ($urandom_range(3) == 0) ? int'($urandom_range(12)) : -1;
      run_fill(($urandom_range(4) == 0), s, e, 3'($urandom), 1'($urandom), ak,
               1'($urandom), 1'($urandom), 1'($urandom), "R3");
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule